// File: doc/BRIEF.md
# Rotating Mailbox Command Writer

This block hands short commands from on-chip logic to a device that reads them out of four mailbox slots. A command is an 8-bit element identifier plus a payload of one to five bytes. Once a command is accepted, the block reads two device status bytes to find out whether the current slot has been consumed. If the slot is still occupied, it keeps polling with a fixed delay between checks, up to a bounded number of checks. When the slot is free, it writes the command into that slot's byte registers over a byte-wide write port, and the next command then goes to the following slot.

Each slot has a four-byte main register and a two-byte extension register. Short commands use only the main register. Long commands set a flag bit and put their first two payload bytes into the extension register, which is written first. The block takes one command at a time. A request raised while the block is busy is held off until the block is free. If that wait goes on too long, the request is dropped with a pulse.

The block is one state machine with these states:
- `ST_IDLE`: waits for a request.
- `ST_RD_TRIG`: reads the trigger status byte.
- `ST_RD_TEST`: reads the slot's test byte and captures the trigger byte.
- `ST_EVAL`: decides free, retry or give up.
- `ST_WAIT`: the pause between checks.
- `ST_WR_EXT`: writes the two extension bytes.
- `ST_WR_MAIN`: writes the four main bytes.
- `ST_DONE`: reports success.
- `ST_FAIL`: reports a timeout.

Its transitions are:
- accept: `ST_IDLE` to `ST_RD_TRIG`.
- reject: stay in `ST_IDLE` on a bad length.
- check: `ST_RD_TRIG` to `ST_RD_TEST` to `ST_EVAL`.
- free-long: `ST_EVAL` to `ST_WR_EXT`.
- free-short: `ST_EVAL` to `ST_WR_MAIN`.
- busy: `ST_EVAL` to `ST_WAIT`.
- give-up: `ST_EVAL` to `ST_FAIL`.
- recheck: `ST_WAIT` to `ST_RD_TRIG`.
- ext-done: `ST_WR_EXT` to `ST_WR_MAIN`.
- main-done: `ST_WR_MAIN` to `ST_DONE`.
- return: `ST_DONE` or `ST_FAIL` to `ST_IDLE`.

Top module: `mbox_cmd_writer`

## Requirements
- R1: Successful commands use slots 0, 1, 2, 3, 0, … in turn, starting at slot 0 after reset. The slot index advances only when a command has been fully written. A failed or rejected command leaves the slot index unchanged.
- R2: The status port returns data one cycle after `rd_en`. The trigger status byte is at 0x0CC, and slot s's test byte is at 0x1B8+s. Slot s is free only when bit s of the trigger byte is 0 and its test byte is 0x00. The other trigger bits and the other slots' test bytes have no effect.
- R3: If the slot is busy, the block waits CHECK_DELAY cycles and then checks again. Consecutive trigger-byte reads are therefore 3+CHECK_DELAY cycles apart. After CHECK_LIMIT busy checks, `cmd_fail` pulses and no register is written.
- R4: For lengths 1 to 3, main byte 0 is the identifier with bit 7 cleared. Main bytes 1 to length carry payload bytes 0 onward (payload byte k is `cmd_payload[8k+7:8k]`). The remaining main bytes are 0x00, and no extension byte is written.
- R5: For lengths 4 and 5, main byte 0 is the identifier with bit 7 set. Extension bytes 0 and 1 get payload bytes 0 and 1. Main bytes 1, 2 and 3 get payload bytes 2, 3 and 4, with byte 4 written as 0x00 when the length is 4.
- R6: Slot s's main byte b is written at 0x1D0+4s+b, and its extension byte e at 0x1F0+2s+e. The writes go out on consecutive cycles: the extension bytes first (if used), then main bytes 0 to 3 in ascending order.
- R7: A request with a length of 0, 6 or 7 gets `cmd_ack` together with `cmd_err`. No status read and no register write follows.
- R8: A request raised while a command is in progress is not acknowledged. It is accepted in the cycle after that command's `cmd_done` or `cmd_fail`.
- R9: If a request is held REQ_WAIT_MAX cycles while the block is busy, `cmd_drop` pulses in the last of those cycles, and the request is not acknowledged in that cycle.
- R10: `cmd_done` pulses in the cycle after the last main byte is written. `cmd_done`, `cmd_fail` and `cmd_err` are never asserted together.
- R11: Coming out of reset, the block is idle. It drives no read, no write and no handshake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Command request, held until acknowledged or dropped |
| cmd_id | input | 8 | Element identifier |
| cmd_len | input | 3 | Payload length in bytes |
| cmd_payload | input | 40 | Payload, byte k in bits 8k+7:8k |
| cmd_ack | output | 1 | Request taken this cycle |
| cmd_err | output | 1 | Request taken but rejected for its length |
| cmd_drop | output | 1 | Held request abandoned |
| cmd_done | output | 1 | Command written to its slot |
| cmd_fail | output | 1 | Slot never freed, command aborted |
| wr_en | output | 1 | Register byte write strobe |
| wr_addr | output | ADDR_W | Register byte write address |
| wr_data | output | 8 | Register byte write data |
| rd_en | output | 1 | Status read strobe |
| rd_addr | output | ADDR_W | Status read address |
| rd_data | input | 8 | Status read data, one cycle after `rd_en` |

## Verification
The bound checker checks several write properties on every cycle:
- an extension write is always followed by another write;
- a flagged main byte 0 directly follows an extension write;
- main bytes climb by one address per cycle;
- completion follows the last main byte;
- a timeout follows a status read;
- the three outcome pulses are mutually exclusive.

Only the bench scenarios can show the rest. These are the slot rotation and its wrap, the zero padding of each length, the immunity to the other slots' status, the exact number and spacing of status checks before a timeout, the wait count before a held request is dropped, and that a queued request is taken right after completion.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned NUM_SLOTS   = 4;
    localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS);
    localparam int unsigned MAIN_BYTES  = 4;
    localparam int unsigned EXT_BYTES   = 2;
    localparam int unsigned PAYLOAD_MAX = 5;
    localparam int unsigned LONG_MIN    = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_TRIG,
        ST_RD_TEST,
        ST_EVAL,
        ST_WAIT,
        ST_WR_EXT,
        ST_WR_MAIN,
        ST_DONE,
        ST_FAIL
    } mbox_state_t;
endpackage

// File: rtl/mbox_encoder.sv
module mbox_encoder
    import mbox_pkg::*;
(
    input  logic [7:0]                 id,
    input  logic [2:0]                 len,
    input  logic [8*PAYLOAD_MAX-1:0]   payload,
    output logic [8*MAIN_BYTES-1:0]    main_b,
    output logic [8*EXT_BYTES-1:0]     ext_b,
    output logic                       use_ext,
    output logic                       len_ok
);
    logic [7:0] pm [PAYLOAD_MAX];

    // bytes past the declared length are forced to zero
    for (genvar k = 0; k < PAYLOAD_MAX; k++) begin : g_mask
        assign pm[k] = (3'(k) < len) ? payload[8*k +: 8] : 8'h00;
    end

    assign use_ext = (len >= 3'(LONG_MIN));
    assign len_ok  = (len != 3'd0) && (len <= 3'(PAYLOAD_MAX));

    always_comb begin
        if (use_ext) begin
            ext_b  = {pm[1], pm[0]};
            main_b = {pm[4], pm[3], pm[2], id | 8'h80};
        end else begin
            ext_b  = '0;
            main_b = {pm[2], pm[1], pm[0], id & 8'h7F};
        end
    end
endmodule

// File: rtl/mbox_pacer.sv
module mbox_pacer #(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CNT_W'(DELAY - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/mbox_cmd_writer.sv
module mbox_cmd_writer
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'h0CC,
    parameter logic [ADDR_W-1:0] TEST_BASE = 12'h1B8,
    parameter logic [ADDR_W-1:0] MAIN_BASE = 12'h1D0,
    parameter logic [ADDR_W-1:0] EXT_BASE  = 12'h1F0,
    parameter int unsigned CHECK_LIMIT  = 100,
    parameter int unsigned CHECK_DELAY  = 4,
    parameter int unsigned REQ_WAIT_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_req,
    input  logic [7:0]        cmd_id,
    input  logic [2:0]        cmd_len,
    input  logic [39:0]       cmd_payload,
    output logic              cmd_ack,
    output logic              cmd_err,
    output logic              cmd_drop,
    output logic              cmd_done,
    output logic              cmd_fail,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int unsigned ATT_W = $clog2(CHECK_LIMIT + 1);
    localparam int unsigned RW_W  = $clog2(REQ_WAIT_MAX + 1);

    mbox_state_t state, state_n;
    logic [SLOT_W-1:0]        slot;
    logic [1:0]               idx;
    logic [ATT_W-1:0]         att;
    logic [RW_W-1:0]          rwait;
    logic [7:0]               trig_q;
    logic [8*MAIN_BYTES-1:0]  main_q, enc_main;
    logic [8*EXT_BYTES-1:0]   ext_q, enc_ext;
    logic                     long_q, enc_long, enc_ok;
    logic                     load_pace, pace_exp, slot_free, accept;

    mbox_encoder u_enc (
        .id      (cmd_id),
        .len     (cmd_len),
        .payload (cmd_payload),
        .main_b  (enc_main),
        .ext_b   (enc_ext),
        .use_ext (enc_long),
        .len_ok  (enc_ok)
    );

    mbox_pacer #(.DELAY(CHECK_DELAY)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_pace),
        .expired (pace_exp)
    );

    assign slot_free = !trig_q[slot] && (rd_data == 8'h00);
    assign accept    = (state == ST_IDLE) && cmd_req && enc_ok;

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            slot   <= '0;
            idx    <= '0;
            att    <= '0;
            rwait  <= '0;
            trig_q <= '0;
            main_q <= '0;
            ext_q  <= '0;
            long_q <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) begin
                main_q <= enc_main;
                ext_q  <= enc_ext;
                long_q <= enc_long;
                att    <= '0;
            end
            if (state == ST_RD_TEST) trig_q <= rd_data;
            if (state == ST_EVAL) begin
                idx <= '0;
                if (!slot_free) att <= att + 1'b1;
            end
            if (state == ST_WR_EXT)  idx <= (idx == 2'd1) ? 2'd0 : idx + 1'b1;
            if (state == ST_WR_MAIN) begin
                idx <= idx + 1'b1;
                if (idx == 2'd3) slot <= slot + 1'b1;
            end
            if (state != ST_IDLE && cmd_req)
                rwait <= (rwait == RW_W'(REQ_WAIT_MAX - 1)) ? '0 : rwait + 1'b1;
            else
                rwait <= '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        load_pace = 1'b0;
        cmd_ack   = 1'b0;
        cmd_err   = 1'b0;
        cmd_done  = 1'b0;
        cmd_fail  = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        rd_en     = 1'b0;
        rd_addr   = TRIG_ADDR;
        cmd_drop  = (state != ST_IDLE) && cmd_req &&
                    (rwait == RW_W'(REQ_WAIT_MAX - 1));
        unique case (state)
            ST_IDLE: begin
                if (cmd_req) begin
                    cmd_ack = 1'b1;
                    if (!enc_ok) cmd_err = 1'b1;
                    else         state_n = ST_RD_TRIG;
                end
            end
            ST_RD_TRIG: begin
                rd_en   = 1'b1;
                rd_addr = TRIG_ADDR;
                state_n = ST_RD_TEST;
            end
            ST_RD_TEST: begin
                rd_en   = 1'b1;
                rd_addr = TEST_BASE + {{(ADDR_W-SLOT_W){1'b0}}, slot};
                state_n = ST_EVAL;
            end
            ST_EVAL: begin
                if (slot_free) begin
                    state_n = long_q ? ST_WR_EXT : ST_WR_MAIN;
                end else if (att == ATT_W'(CHECK_LIMIT - 1)) begin
                    state_n = ST_FAIL;
                end else begin
                    state_n   = ST_WAIT;
                    load_pace = 1'b1;
                end
            end
            ST_WAIT: begin
                if (pace_exp) state_n = ST_RD_TRIG;
            end
            ST_WR_EXT: begin
                wr_en   = 1'b1;
                wr_addr = EXT_BASE + {{(ADDR_W-SLOT_W-1){1'b0}}, slot, idx[0]};
                wr_data = ext_q[8*idx[0] +: 8];
                if (idx == 2'd1) state_n = ST_WR_MAIN;
            end
            ST_WR_MAIN: begin
                wr_en   = 1'b1;
                wr_addr = MAIN_BASE + {{(ADDR_W-SLOT_W-2){1'b0}}, slot, idx};
                wr_data = main_q[8*idx +: 8];
                if (idx == 2'd3) state_n = ST_DONE;
            end
            ST_DONE: begin
                cmd_done = 1'b1;
                state_n  = ST_IDLE;
            end
            ST_FAIL: begin
                cmd_fail = 1'b1;
                state_n  = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mbox_cmd_writer_chk.sv
module mbox_cmd_writer_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] MAIN_BASE = 12'h1D0,
    parameter logic [ADDR_W-1:0] EXT_BASE  = 12'h1F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic              cmd_done,
    input logic              cmd_fail,
    input logic              cmd_err
);
    logic [ADDR_W-1:0] main_off, ext_off;
    logic              in_main, in_ext;
    logic [1:0]        main_pos;

    assign main_off = wr_addr - MAIN_BASE;
    assign ext_off  = wr_addr - EXT_BASE;
    assign in_main  = main_off < ADDR_W'(16);
    assign in_ext   = ext_off < ADDR_W'(8);
    assign main_pos = wr_addr[1:0] - MAIN_BASE[1:0];

    // R10
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_done, cmd_fail, cmd_err}));

    // R6
    ext_then_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_ext) |=> (wr_en && (in_ext || in_main)));

    // R5
    flag_after_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_main && main_pos == 2'd0 && wr_data[7]) |->
            ($past(wr_en) && $past(in_ext)));

    // R6
    main_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_main && main_pos != 2'd0) |->
            ($past(wr_en) && (($past(wr_addr) + ADDR_W'(1)) == wr_addr)));

    // R10
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ($past(wr_en) && $past(in_main) && $past(main_pos) == 2'd3));

    // R3
    fail_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fail |-> ($past(rd_en, 2) && !$past(wr_en)));
endmodule

bind mbox_cmd_writer mbox_cmd_writer_chk #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .EXT_BASE(EXT_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .cmd_done(cmd_done),
    .cmd_fail(cmd_fail), .cmd_err(cmd_err)
);

// File: tb/mbox_cmd_writer_tb_top.sv
`timescale 1ns/1ps
module mbox_cmd_writer_tb_top;
    localparam int TRIG   = 'h0CC;
    localparam int TESTB  = 'h1B8;
    localparam int MAINB  = 'h1D0;
    localparam int EXTB   = 'h1F0;
    localparam int LIMIT  = 100;
    localparam int DELAY  = 4;
    localparam int RWMAX  = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_req = 1'b0;
    logic [7:0]  cmd_id = '0;
    logic [2:0]  cmd_len = '0;
    logic [39:0] cmd_payload = '0;
    logic        cmd_ack, cmd_err, cmd_drop, cmd_done, cmd_fail;
    logic        wr_en, rd_en;
    logic [11:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = '0;

    logic [7:0]  trig_reg = '0;
    logic [7:0]  test_reg [4] = '{default: 8'h00};

    int checks = 0, failures = 0;
    int cyc = 0, done_cnt = 0, fail_cnt = 0, trig_reads = 0, any_rd = 0;
    int model_slot = 0;
    int exp_a[$], exp_d[$], trig_t[$];

    always #4 clk = ~clk;

    mbox_cmd_writer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_id(cmd_id),
        .cmd_len(cmd_len), .cmd_payload(cmd_payload), .cmd_ack(cmd_ack),
        .cmd_err(cmd_err), .cmd_drop(cmd_drop), .cmd_done(cmd_done),
        .cmd_fail(cmd_fail), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // device status registers, one-cycle read latency
    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr == 12'(TRIG))
                rd_data <= trig_reg;
            else if (rd_addr >= 12'(TESTB) && rd_addr < 12'(TESTB + 4))
                rd_data <= test_reg[rd_addr - 12'(TESTB)];
            else
                rd_data <= 8'hEE;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (wr_en) begin
                if (exp_a.size() == 0) begin
                    check(1'b0, "R3 R7 unexpected write", int'(wr_addr), -1);
                end else begin
                    int ea, ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    check(int'(wr_addr) == ea, "R6 write address", int'(wr_addr), ea);
                    check(int'(wr_data) == ed, "R4 R5 write data", int'(wr_data), ed);
                end
            end
            if (rd_en) any_rd++;
            if (rd_en && rd_addr == 12'(TRIG)) begin
                trig_reads++;
                trig_t.push_back(cyc);
            end
            if (cmd_done) begin
                done_cnt++;
                model_slot = (model_slot + 1) % 4;
            end
            if (cmd_fail) fail_cnt++;
        end
    end

    function automatic logic [7:0] pb(input logic [39:0] p, input int k, input int len);
        return (k < len) ? p[8*k +: 8] : 8'h00;
    endfunction

    task automatic push_expect(input logic [7:0] id, input int len, input logic [39:0] p);
        int s;
        s = model_slot;
        if (len >= 4) begin
            exp_a.push_back(EXTB + 2*s);     exp_d.push_back(pb(p, 0, len));
            exp_a.push_back(EXTB + 2*s + 1); exp_d.push_back(pb(p, 1, len));
            exp_a.push_back(MAINB + 4*s);    exp_d.push_back(id | 8'h80);
            exp_a.push_back(MAINB + 4*s + 1); exp_d.push_back(pb(p, 2, len));
            exp_a.push_back(MAINB + 4*s + 2); exp_d.push_back(pb(p, 3, len));
            exp_a.push_back(MAINB + 4*s + 3); exp_d.push_back(pb(p, 4, len));
        end else begin
            exp_a.push_back(MAINB + 4*s);    exp_d.push_back(id & 8'h7F);
            for (int k = 0; k < 3; k++) begin
                exp_a.push_back(MAINB + 4*s + 1 + k);
                exp_d.push_back(pb(p, k, len));
            end
        end
    endtask

    task automatic send(input logic [7:0] id, input int len, input logic [39:0] p,
                        input bit expect_ok, output bit got_ack, output bit got_err,
                        output bit got_drop, output int waited);
        bit a, e, d;
        waited = 0;
        @(negedge clk);
        cmd_id = id; cmd_len = 3'(len); cmd_payload = p; cmd_req = 1'b1;
        forever begin
            #1;
            a = cmd_ack; e = cmd_err; d = cmd_drop;
            waited++;
            @(negedge clk);
            if (a || d || waited > 5000) break;
        end
        cmd_req = 1'b0;
        got_ack = a; got_err = e; got_drop = d;
        if (a && !e && expect_ok) push_expect(id, len, p);
    endtask

    task automatic wait_done(input int target);
        int n = 0;
        while (done_cnt < target && n < 3000) begin @(negedge clk); n++; end
        check(done_cnt == target, "R10 completion pulse", done_cnt, target);
        check(exp_a.size() == 0, "R6 all writes seen", exp_a.size(), 0);
    endtask

    task automatic wait_fail(input int target);
        int n = 0;
        while (fail_cnt < target && n < 3000) begin @(negedge clk); n++; end
        check(fail_cnt == target, "R3 failure pulse", fail_cnt, target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit a, e, d;
        int w, dc, t0, rd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11
        check({wr_en, rd_en, cmd_ack, cmd_done, cmd_fail, cmd_drop, cmd_err} == 7'b0,
              "R11 idle after reset", {wr_en, rd_en, cmd_ack, cmd_done}, 0);

        // R4 R1: short commands, slot 0 then 1
        send(8'h85, 1, 40'h11_22_33_44_AA, 1, a, e, d, w);
        check(a && !e, "R4 accept len1", {a, e}, 2);
        wait_done(1);
        send(8'h12, 3, 40'hFF_EE_C3_B2_A1, 1, a, e, d, w);
        wait_done(2);
        // R5: long commands on slots 2 and 3
        send(8'h40, 4, 40'h99_44_33_22_11, 1, a, e, d, w);
        wait_done(3);
        send(8'hC7, 5, 40'h55_44_33_22_11, 1, a, e, d, w);
        wait_done(4);
        // R1: wrap to slot 0
        send(8'h21, 2, 40'h00_00_00_6B_5A, 1, a, e, d, w);
        wait_done(5);
        check(model_slot == 1, "R1 wrap to slot 1 next", model_slot, 1);

        // R7: bad lengths
        rd0 = any_rd;
        send(8'h33, 0, 40'h1, 1, a, e, d, w);
        check(a && e, "R7 len0 rejected", {a, e}, 3);
        send(8'h33, 6, 40'h1, 1, a, e, d, w);
        check(a && e, "R7 len6 rejected", {a, e}, 3);
        repeat (20) @(negedge clk);
        check(any_rd == rd0, "R7 no status read", any_rd - rd0, 0);
        send(8'h0A, 1, 40'h7E, 1, a, e, d, w);   // must land on slot 1
        wait_done(6);

        // R2: other slots' status ignored
        trig_reg = 8'hFB; test_reg[0] = 8'h5; test_reg[1] = 8'h9; test_reg[3] = 8'h1;
        rd0 = trig_reads;
        send(8'h0B, 2, 40'h1234, 1, a, e, d, w);  // slot 2
        wait_done(7);
        check(trig_reads - rd0 == 1, "R2 free on first check", trig_reads - rd0, 1);
        // R2: own test byte busy, then cleared
        trig_reg = 8'h00; test_reg = '{default: 8'h00}; test_reg[3] = 8'h44;
        rd0 = trig_reads;
        send(8'h0C, 3, 40'h030201, 1, a, e, d, w); // slot 3
        repeat (40) @(negedge clk);
        check(done_cnt == 7, "R2 held while test byte set", done_cnt, 7);
        test_reg[3] = 8'h00;
        wait_done(8);
        check(trig_reads - rd0 > 1, "R2 rechecked", trig_reads - rd0, 2);

        // R3: timeout on slot 0
        trig_reg = 8'h01;
        trig_reads = 0; trig_t.delete();
        send(8'h0D, 1, 40'h1, 0, a, e, d, w);
        wait_fail(1);
        check(trig_reads == LIMIT, "R3 check count", trig_reads, LIMIT);
        check(trig_t.size() > 1 && trig_t[1] - trig_t[0] == 3 + DELAY,
              "R3 check spacing", (trig_t.size() > 1) ? trig_t[1] - trig_t[0] : -1, 3 + DELAY);
        check(model_slot == 0, "R1 no advance on fail", model_slot, 0);

        // R9: held request dropped
        send(8'h0E, 1, 40'h1, 0, a, e, d, w);
        send(8'h0F, 1, 40'h2, 0, a, e, d, w);
        check(d && !a, "R9 drop without ack", {a, d}, 1);
        check(w == RWMAX, "R9 wait length", w, RWMAX);
        wait_fail(2);

        // R8: queued request accepted after completion; R1 slot 0 still
        send(8'h10, 5, 40'hA5_A4_A3_A2_A1, 1, a, e, d, w);
        fork
            begin repeat (50) @(negedge clk); trig_reg = 8'h00; end
        join_none
        dc = done_cnt;
        send(8'h11, 4, 40'h00_B4_B3_B2_B1, 1, a, e, d, w);
        check(a && !d && w > 1, "R8 queued accept", {a, d}, 2);
        check(done_cnt == dc + 1, "R8 accepted after done", done_cnt, dc + 1);
        wait_done(10);
        check(model_slot == 2, "R1 slot after queued pair", model_slot, 2);

        t0 = cyc;
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule